// File: doc/BRIEF.md
# Sticky Status and Interrupt Register

This block holds the event status of a measurement device and drives a single active-high interrupt. The measurement logic reports conditions as one-cycle or level event inputs. Each condition latches a status bit that stays set until the host clears it over a small register bus. A mask register, read and written over the same bus, selects which conditions may assert the interrupt.

Most status bits are sticky and cleared by writing one to them. Four positions follow their own rules:

- **Command-valid flag:** active-low, so it rests at one and drops to zero when an invalid command arrives. Only a port-initialization pulse or reset brings it back, and bus writes do not affect it.
- **Low-supply bit:** a clear only takes effect while the supply-good indication is asserted.
- **Oscillation-detect bits:** these set again at once after a clear if the overload is still present.
- **Revision field:** a constant four-bit field that software can only read.

The host reads status at address 0 and the mask at address 1. Read data appears one cycle after the read strobe.

Top module: `stat_irq_reg`

## Requirements
- R1: After reset, status reads 0x8000 with the revision parameter in bits 11:8 (0x8300 for revision 3), the mask reads 0x0000, and irq_o is 0.
- R2: A high level on oor_evt_i[k] sets status bit k (k = 0..7). A high level on osc_evt_i[j] sets status bit 12+j (j = 0 is current, j = 1 is voltage). These bits stay set after the input returns low.
- R3: A write to address 0 clears every sticky bit in positions 7:0 and 14:12 whose write-data bit is 1. Bits written with 0 are unchanged.
- R4: When an event and a clear of the same bit fall in the same cycle, the bit stays set. An oscillation bit whose input is still high therefore remains set after a clear.
- R5: Status bit 15 is the command-valid flag. It resets to 1 and goes to 0 one cycle after a bad_cmd_i pulse. Writes to address 0 never change it.
- R6: A port_init_i pulse returns status bit 15 to 1. If bad_cmd_i is high in the same cycle, bad_cmd_i takes precedence and the bit goes to 0.
- R7: Status bit 14 (low supply) sets while supply_low_i is high. A write-one clear of bit 14 takes effect only when supply_good_i is high and supply_low_i is low; otherwise the bit stays set.
- R8: Status bits 11:8 always read the REV parameter, and writes do not change them.
- R9: The mask is written at address 1 and read back from there. Mask bits 11:8 always read 0.
- R10: irq_o is 1 exactly when some masked bit is pending. A bit in positions 7:0 or 14:12 is pending when it is 1. Bit 15 is pending when the command-valid flag is 0. The revision field never contributes.
- R11: rdata_o shows the addressed register one cycle after rd_en_i. Addresses 2 and 3 read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| oor_evt_i | input | 8 | Out-of-range and math-overflow events |
| osc_evt_i | input | 2 | Modulator-oscillation events (0 current, 1 voltage) |
| bad_cmd_i | input | 1 | Invalid-command pulse |
| port_init_i | input | 1 | Port-initialization pulse |
| supply_low_i | input | 1 | Supply below low threshold |
| supply_good_i | input | 1 | Supply above high threshold |
| irq_o | output | 1 | Interrupt, active high |

## Verification
A lost or stuck status bit shows up on the next status read, which returns data one cycle after the strobe. When the matching mask bit is set, the same fault also moves irq_o in the very next cycle. The test set covers the following:
- the command-valid flag is read after writes that try to change it;
- the low-supply bit is read after a clear attempted without the supply-good indication;
- an event and a clear of the same bit are applied in the same cycle.

A polarity error on the flag or a leaking revision bit shows up as an interrupt raised under a full mask with no pending event.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int DW    = 16;
  localparam int AW    = 2;
  localparam int OOR_N = 8;
  localparam int OSC_N = 2;
  localparam int REV_W = 4;

  localparam int OOR_LSB = 0;
  localparam int REV_LSB = 8;
  localparam int OSC_LSB = 12;
  localparam int LSD_BIT = 14;
  localparam int CMD_BIT = 15;

  localparam logic [AW-1:0] A_STATUS = AW'(0);
  localparam logic [AW-1:0] A_MASK   = AW'(1);

  localparam logic [DW-1:0] REV_FIELD = DW'(((1 << REV_W) - 1) << REV_LSB);
  localparam logic [DW-1:0] MASK_WR   = ~REV_FIELD;
endpackage

// File: rtl/stat_w1c_bank.sv
module stat_w1c_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic q;
    // set dominates clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[k] | (q & ~clr_i[k]);
    end
    assign q_o[k] = q;
  end
endmodule

// File: rtl/stat_lsd_cell.sv
module stat_lsd_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  input  logic good_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= low_i | (q_o & ~(clr_i & good_i));
  end
endmodule

// File: rtl/stat_cmd_flag.sv
module stat_cmd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bad_i,
  input  logic init_i,
  output logic ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ok_o <= 1'b1;
    else if (bad_i)  ok_o <= 1'b0;
    else if (init_i) ok_o <= 1'b1;
  end
endmodule

// File: rtl/stat_irq_regif.sv
module stat_irq_regif
  import stat_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] clr_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] rdata_o
);
  logic wr_status, wr_mask;
  logic [DW-1:0] rd_mux;

  assign wr_status = wr_en_i && (addr_i == A_STATUS);
  assign wr_mask   = wr_en_i && (addr_i == A_MASK);
  assign clr_o     = wr_status ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_o <= '0;
    else if (wr_mask) mask_o <= wdata_i & MASK_WR;
  end

  always_comb begin
    unique case (addr_i)
      A_STATUS: rd_mux = status_i;
      A_MASK:   rd_mux = mask_o;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/stat_irq_reg.sv
module stat_irq_reg
  import stat_irq_pkg::*;
#(
  parameter logic [REV_W-1:0] REV = 4'h3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [OOR_N-1:0]    oor_evt_i,
  input  logic [OSC_N-1:0]    osc_evt_i,
  input  logic                bad_cmd_i,
  input  logic                port_init_i,
  input  logic                supply_low_i,
  input  logic                supply_good_i,
  output logic                irq_o
);
  localparam int STK_N = OOR_N + OSC_N;

  logic [DW-1:0]    status_q, mask_q, clr;
  logic [DW-1:0]    pend;
  logic [STK_N-1:0] stk_set, stk_clr, stk_q;
  logic             lsd_q, cmd_ok_q;

  assign stk_set = {osc_evt_i, oor_evt_i};
  assign stk_clr = {clr[OSC_LSB +: OSC_N], clr[OOR_LSB +: OOR_N]};

  stat_w1c_bank #(.N(STK_N)) u_stk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (stk_set),
    .clr_i (stk_clr),
    .q_o   (stk_q)
  );

  stat_lsd_cell u_lsd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .low_i (supply_low_i),
    .good_i(supply_good_i),
    .clr_i (clr[LSD_BIT]),
    .q_o   (lsd_q)
  );

  stat_cmd_flag u_cmd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bad_i (bad_cmd_i),
    .init_i(port_init_i),
    .ok_o  (cmd_ok_q)
  );

  always_comb begin
    status_q                        = '0;
    status_q[OOR_LSB +: OOR_N]      = stk_q[OOR_N-1:0];
    status_q[REV_LSB +: REV_W]      = REV;
    status_q[OSC_LSB +: OSC_N]      = stk_q[STK_N-1:OOR_N];
    status_q[LSD_BIT]               = lsd_q;
    status_q[CMD_BIT]               = cmd_ok_q;
  end

  stat_irq_regif u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .rd_en_i (rd_en_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .status_i(status_q),
    .clr_o   (clr),
    .mask_o  (mask_q),
    .rdata_o (rdata_o)
  );

  // command flag is active low; revision field never pends
  always_comb begin
    pend          = status_q & ~REV_FIELD;
    pend[CMD_BIT] = ~cmd_ok_q;
  end

  assign irq_o = |(pend & mask_q);
endmodule

// File: rtl/stat_irq_reg_chk.sv
module stat_irq_reg_chk
  import stat_irq_pkg::*;
#(
  parameter logic [REV_W-1:0] REV = 4'h3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             wr_en_i,
  input logic [DW-1:0]    wdata_i,
  input logic [OOR_N-1:0] oor_evt_i,
  input logic             bad_cmd_i,
  input logic             port_init_i,
  input logic             supply_good_i,
  input logic [DW-1:0]    status_q,
  input logic [DW-1:0]    mask_q,
  input logic             irq_o
);
  logic wr_st;
  assign wr_st = wr_en_i && (addr_i == A_STATUS);

  p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|oor_evt_i) |=> ((status_q[7:0] & $past(oor_evt_i)) == $past(oor_evt_i)));

  p_clear_needs_w1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_q[7:0]) & ~status_q[7:0])
               & ~($past(wr_st) ? $past(wdata_i[7:0]) : 8'h00)) == 8'h00));

  p_evt_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && (|(wdata_i[7:0] & oor_evt_i)))
      |=> ((status_q[7:0] & $past(oor_evt_i & wdata_i[7:0])) == $past(oor_evt_i & wdata_i[7:0])));

  p_cmd_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cmd_i |=> !status_q[CMD_BIT]);

  p_cmd_write_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_q[CMD_BIT] && !port_init_i && wr_st) |=> !status_q[CMD_BIT]);

  p_cmd_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_init_i && !bad_cmd_i) |=> status_q[CMD_BIT]);

  p_lsd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[LSD_BIT] && !supply_good_i) |=> status_q[LSD_BIT]);

  p_rev_const_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[REV_LSB +: REV_W] == REV);

  p_mask_rev_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[REV_LSB +: REV_W] == '0);

  p_irq_needs_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

bind stat_irq_reg stat_irq_reg_chk #(.REV(REV)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wr_en_i      (wr_en_i),
  .wdata_i      (wdata_i),
  .oor_evt_i    (oor_evt_i),
  .bad_cmd_i    (bad_cmd_i),
  .port_init_i  (port_init_i),
  .supply_good_i(supply_good_i),
  .status_q     (status_q),
  .mask_q       (mask_q),
  .irq_o        (irq_o)
);

// File: tb/stat_irq_reg_bench.sv
module stat_irq_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  oor_evt = '0;
  logic [1:0]  osc_evt = '0;
  logic        bad_cmd = 1'b0, port_init = 1'b0;
  logic        sup_low = 1'b0, sup_good = 1'b1;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  stat_irq_reg u_stat_irq_reg (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .oor_evt_i(oor_evt), .osc_evt_i(osc_evt), .bad_cmd_i(bad_cmd),
    .port_init_i(port_init), .supply_low_i(sup_low),
    .supply_good_i(sup_good), .irq_o(irq)
  );

  // monitor: compare read data one cycle after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_evt(input logic [1:0] a, input logic [15:0] d, input logic [7:0] ev);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; oor_evt = ev;
    @(negedge clk);
    wr_en = 1'b0; oor_evt = '0;
  endtask

  task automatic pulse_oor(input logic [7:0] ev);
    @(negedge clk); oor_evt = ev;
    @(negedge clk); oor_evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(2'd0, 16'h8300, "R1 status");
    rd(2'd1, 16'h0000, "R1 mask");
    // R2 sticky set
    pulse_oor(8'h05);
    rd(2'd0, 16'h8305, "R2 oor sticky");
    // R3 clear by one, zero no effect
    wr(2'd0, 16'h0001);
    rd(2'd0, 16'h8304, "R3 w1c");
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h8304, "R3 w0 keeps");
    // R8 and R5: clear-all leaves rev and flag
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'h8300, "R8 rev kept / R3 all cleared");
    // R4 event wins over clear
    pulse_oor(8'h10);
    wr_evt(2'd0, 16'h0010, 8'h10);
    rd(2'd0, 16'h8310, "R4 event wins");
    wr(2'd0, 16'h0010);
    rd(2'd0, 16'h8300, "R4 cleared later");
    // R2/R4 oscillation bit with held overload
    @(negedge clk); osc_evt = 2'b01;
    wr(2'd0, 16'h1000);
    rd(2'd0, 16'h9300, "R4 osc reasserts");
    @(negedge clk); osc_evt = 2'b10;
    @(negedge clk); osc_evt = 2'b00;
    wr(2'd0, 16'h1000);
    rd(2'd0, 16'hA300, "R2 voltage osc sticky");
    wr(2'd0, 16'h2000);
    // R5 invalid command
    @(negedge clk); bad_cmd = 1'b1;
    @(negedge clk); bad_cmd = 1'b0;
    rd(2'd0, 16'h0300, "R5 flag low");
    wr(2'd0, 16'h8000);
    rd(2'd0, 16'h0300, "R5 write ignored");
    // R6 port init, and bad_cmd precedence
    @(negedge clk); port_init = 1'b1; bad_cmd = 1'b1;
    @(negedge clk); port_init = 1'b0; bad_cmd = 1'b0;
    rd(2'd0, 16'h0300, "R6 bad wins over init");
    @(negedge clk); port_init = 1'b1;
    @(negedge clk); port_init = 1'b0;
    rd(2'd0, 16'h8300, "R6 restored");
    // R7 low supply
    @(negedge clk); sup_low = 1'b1; sup_good = 1'b0;
    @(negedge clk); sup_low = 1'b0;
    wr(2'd0, 16'h4000);
    rd(2'd0, 16'hC300, "R7 clear blocked");
    @(negedge clk); sup_good = 1'b1;
    wr(2'd0, 16'h4000);
    rd(2'd0, 16'h8300, "R7 clear with good");
    // R9 mask
    wr(2'd1, 16'hFFFF);
    rd(2'd1, 16'hF0FF, "R9 mask rev bits zero");
    chk_irq(1'b0, "R10 nothing pending full mask");
    // R10 interrupt
    wr(2'd1, 16'h0002);
    pulse_oor(8'h02);
    chk_irq(1'b1, "R10 masked bit raises");
    wr(2'd1, 16'h0001);
    chk_irq(1'b0, "R10 unmasked bit quiet");
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'h8000);
    chk_irq(1'b0, "R10 flag ok no irq");
    @(negedge clk); bad_cmd = 1'b1;
    @(negedge clk); bad_cmd = 1'b0;
    chk_irq(1'b1, "R10 invalid cmd irq");
    @(negedge clk); port_init = 1'b1;
    @(negedge clk); port_init = 1'b0;
    chk_irq(1'b0, "R10 irq drops after init");
    // R11 unmapped
    rd(2'd2, 16'h0000, "R11 addr2");
    rd(2'd3, 16'h0000, "R11 addr3");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule